// File: doc/BRIEF.md
# Integer ALU with Trapping Overflow

This block is the integer execute unit of a small RISC core. It is purely combinational. Each cycle it takes two 32-bit register operands, a 16-bit instruction immediate, an immediate-select bit and a 4-bit operation code. It returns a 32-bit result and a flag that reports signed overflow.

Addition and subtraction come in two kinds. The trapping kind raises the overflow flag when the two's-complement result does not fit. The wrapping kind never raises it. Both kinds produce the same bit pattern. Two less-than compares write 0 or 1: one reads the operands as signed, the other as unsigned.

The block extends the immediate itself, and the operation decides how. Arithmetic and compare operations sign-extend it. AND and OR zero-extend it. There is no subtract-immediate: software adds a negative immediate instead. The block only raises the flag. Suppressing writeback and taking the exception belong to the surrounding pipeline.

Top module: `int_alu_trap`

## Requirements
- R1: Operations ADD (code 0), ADDU (1), SUB (2) and SUBU (3) return the first operand plus or minus the second operand, modulo 2^32.
- R2: ADD and SUB set `ovf_o` to 1 exactly when the true signed result lies outside -2^31 to 2^31-1.
- R3: ADDU and SUBU hold `ovf_o` at 0 for every operand pair, including pairs that overflow under ADD or SUB.
- R4: SLT (code 8) returns 1 when the first operand is less than the second as a signed number, and 0 otherwise. Bits 31 to 1 of the result are always 0.
- R5: SLTU (code 9) compares both operands as unsigned. For 0xFFFFFFFA against 0x0000FFFA, SLT returns 1 and SLTU returns 0.
- R6: When `use_imm_i` is 1, the second operand is `imm_i`. It is sign-extended (bit 15 copied into bits 31 to 16) for codes 0, 1, 2, 3, 8 and 9.
- R7: When `use_imm_i` is 1, AND (code 4) and OR (code 5) zero-extend `imm_i`. AND-immediate then yields 0 in bits 31 to 16, and OR-immediate passes bits 31 to 16 of the first operand through unchanged.
- R8: AND and OR return the bitwise AND or OR of the two operands.
- R9: SLL (code 6) and SRL (code 7) shift the first operand left or right. The shift amount is bits 4 to 0 of the second operand, and vacated bits fill with 0.
- R10: `ovf_o` is 0 for every code other than ADD and SUB. The unassigned codes 10 to 15 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Instruction immediate |
| use_imm_i | input | 1 | Take the extended immediate as the second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow trap flag |

## Verification
The bench drives the overflow boundaries directly: 0x7FFFFFFF+1, 0x80000000-1, 0x80000000+0x80000000, and a subtraction whose operand signs differ but which does not overflow. Each pattern is repeated under the wrapping codes. A design that used an unsigned carry, or the wrong sign rule for subtraction, would flag the wrong cases or flag the wrapping forms. The signed and unsigned compares are checked on the pair 0xFFFFFFFA/0x0000FFFA, where swapping them inverts the answer. Immediates with bit 15 set go to ADD, SLT, AND and OR, which catches a design that extends with the wrong mode. Random operands with shift amounts of 0 and 31 cover fill and masking errors.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned IMMW   = 16;
  localparam int unsigned OPW    = 4;
  localparam int unsigned SHAMTW = $clog2(XLEN);

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } alu_op_e;

  typedef logic [XLEN-1:0] word_t;

  // Widen the immediate: sign-fill unless zero extension is requested.
  function automatic word_t widen_imm(input logic [IMMW-1:0] imm, input logic zero_fill);
    logic fill;
    fill = zero_fill ? 1'b0 : imm[IMMW-1];
    return {{(XLEN-IMMW){fill}}, imm};
  endfunction

  // Signed overflow of x + y (or x - y when is_sub), from the sign bits only.
  function automatic logic signed_ovf(input word_t x, input word_t y,
                                      input word_t r, input logic is_sub);
    logic ys;
    ys = is_sub ? ~y[XLEN-1] : y[XLEN-1];
    return (x[XLEN-1] == ys) && (r[XLEN-1] != x[XLEN-1]);
  endfunction

  // Less-than; signed form flips the sign bits so an unsigned compare can be reused.
  function automatic logic less_than(input word_t x, input word_t y, input logic as_unsigned);
    word_t xs, ys;
    xs = x;
    ys = y;
    if (!as_unsigned) begin
      xs[XLEN-1] = ~x[XLEN-1];
      ys[XLEN-1] = ~y[XLEN-1];
    end
    return xs < ys;
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
  import alu_trap_pkg::*;
(
  input  logic [IMMW-1:0] imm_i,
  input  logic            zero_fill_i,
  output word_t           ext_o
);
  assign ext_o = widen_imm(imm_i, zero_fill_i);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_trap_pkg::*;
(
  input  word_t x_i,
  input  word_t y_i,
  input  logic  sub_i,
  output word_t sum_o,
  output logic  sovf_o
);
  word_t y_eff;
  assign y_eff  = sub_i ? ~y_i : y_i;
  assign sum_o  = x_i + y_eff + {{(XLEN-1){1'b0}}, sub_i};
  assign sovf_o = signed_ovf(x_i, y_i, sum_o, sub_i);
endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import alu_trap_pkg::*;
(
  input  word_t x_i,
  input  word_t y_i,
  input  logic  unsigned_i,
  output logic  lt_o
);
  assign lt_o = less_than(x_i, y_i, unsigned_i);
endmodule

// File: rtl/alu_bitshift.sv
module alu_bitshift
  import alu_trap_pkg::*;
(
  input  word_t      x_i,
  input  word_t      y_i,
  input  logic [1:0] sel_i,   // 0 and, 1 or, 2 sll, 3 srl
  output word_t      out_o
);
  logic [SHAMTW-1:0] shamt;
  assign shamt = y_i[SHAMTW-1:0];

  always_comb begin
    unique case (sel_i)
      2'd0:    out_o = x_i & y_i;
      2'd1:    out_o = x_i | y_i;
      2'd2:    out_o = x_i << shamt;
      default: out_o = x_i >> shamt;
    endcase
  end
endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
  import alu_trap_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [15:0] imm_i,
  input  logic        use_imm_i,
  input  logic [3:0]  op_i,
  output logic [31:0] result_o,
  output logic        ovf_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Named internal events for the checker.
  logic  logic_imm;     // immediate to be zero-extended
  logic  trap_op;       // trapping add/sub selected
  logic  is_sub;
  logic  raw_ovf;       // signed overflow of the adder, regardless of op
  logic  lt_bit;
  word_t imm_ext, opnd_b, sum, bits_out;

  assign logic_imm = (op == OP_AND) || (op == OP_OR);
  assign trap_op   = (op == OP_ADD) || (op == OP_SUB);
  assign is_sub    = (op == OP_SUB) || (op == OP_SUBU);

  alu_imm_ext u_ext (
    .imm_i       (imm_i),
    .zero_fill_i (logic_imm),
    .ext_o       (imm_ext)
  );

  assign opnd_b = use_imm_i ? imm_ext : b_i;

  alu_addsub u_as (
    .x_i    (a_i),
    .y_i    (opnd_b),
    .sub_i  (is_sub),
    .sum_o  (sum),
    .sovf_o (raw_ovf)
  );

  alu_compare u_cmp (
    .x_i        (a_i),
    .y_i        (opnd_b),
    .unsigned_i (op == OP_SLTU),
    .lt_o       (lt_bit)
  );

  alu_bitshift u_bs (
    .x_i   (a_i),
    .y_i   (opnd_b),
    .sel_i (op_i[1:0]),
    .out_o (bits_out)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:  result_o = sum;
      OP_AND, OP_OR, OP_SLL, OP_SRL:     result_o = bits_out;
      OP_SLT, OP_SLTU:                   result_o = {{(XLEN-1){1'b0}}, lt_bit};
      default:                           result_o = '0;
    endcase
  end

  assign ovf_o = trap_op & raw_ovf;
endmodule

// File: rtl/alu_trap_checks.sv
module alu_trap_checks
  import alu_trap_pkg::*;
(
  input logic [31:0] a_i,
  input logic [15:0] imm_i,
  input logic        use_imm_i,
  input logic [3:0]  op_i,
  input logic [31:0] result_o,
  input logic        ovf_o,
  input logic        raw_ovf,
  input logic        trap_op
);
  always_comb begin
    // R3 / R10: flag stays low outside the trapping add and subtract
    if (!trap_op) a_r3_no_overflow: assert (!ovf_o);
    // R2: a trap always reflects a real adder overflow
    if (ovf_o) a_r2_trap_from_adder: assert (raw_ovf);
    // R2: on trapping ADD the result sign departs from the first operand's
    if (ovf_o && op_i == 4'd0) a_r2_add_sign: assert (result_o[31] != a_i[31]);
    // R4 / R5: compares return only 0 or 1
    if (op_i == 4'd8 || op_i == 4'd9) a_r4_bool_result: assert (result_o[31:1] == '0);
    // R7: AND-immediate clears the upper half
    if (use_imm_i && op_i == 4'd4) a_r7_andi_upper: assert (result_o[31:16] == '0);
    // R7: OR-immediate keeps the upper half of the first operand
    if (use_imm_i && op_i == 4'd5) a_r7_ori_upper: assert (result_o[31:16] == a_i[31:16]);
    // R7: OR-immediate sets every low bit that the immediate sets
    if (use_imm_i && op_i == 4'd5) a_r7_ori_low: assert ((result_o[15:0] & imm_i) == imm_i);
    // R10: unassigned codes give zero
    if (op_i > 4'd9) a_r10_unused_zero: assert (result_o == '0 && !ovf_o);
  end
endmodule

bind int_alu_trap alu_trap_checks u_chk (
  .a_i       (a_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o),
  .raw_ovf   (raw_ovf),
  .trap_op   (trap_op)
);

// File: tb/sim_int_alu_trap.sv
module sim_int_alu_trap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic        use_imm, ovf;
  logic [3:0]  op;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  localparam int WATCHDOG = 100000;

  int_alu_trap u0 (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .op_i(op),
    .result_o(res), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // Reference model built from the requirement text.
  function automatic logic [31:0] ref_b(input logic [31:0] rb, input logic [15:0] im,
                                        input logic ui, input logic [3:0] o);
    if (!ui) return rb;
    if (o == 4'd4 || o == 4'd5) return {16'h0000, im};
    return 32'($signed(im));
  endfunction

  function automatic logic [32:0] ref_out(input logic [31:0] x, input logic [31:0] y,
                                          input logic [3:0] o);
    longint sx, sy, wide;
    logic [31:0] r;
    logic f;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    f  = 1'b0;
    r  = 32'h0;
    case (o)
      4'd0, 4'd1: begin wide = sx + sy; r = x + y; f = (o == 4'd0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      4'd2, 4'd3: begin wide = sx - sy; r = x - y; f = (o == 4'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      4'd4: r = x & y;
      4'd5: r = x | y;
      4'd6: for (int i = 0; i < 32; i++) r[i] = (i >= int'(y[4:0])) ? x[i - int'(y[4:0])] : 1'b0;
      4'd7: for (int i = 0; i < 32; i++) r[i] = (i + int'(y[4:0]) < 32) ? x[i + int'(y[4:0])] : 1'b0;
      4'd8: r = (sx < sy) ? 32'd1 : 32'd0;
      4'd9: r = ({32'h0, x} < {32'h0, y}) ? 32'd1 : 32'd0;
      default: r = 32'h0;
    endcase
    return {f, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic ui);
    case (o)
      4'd0, 4'd2: return ui ? "R2/R6" : "R2";
      4'd1, 4'd3: return ui ? "R3/R6" : "R3";
      4'd4, 4'd5: return ui ? "R7" : "R8";
      4'd6, 4'd7: return "R9";
      4'd8:       return "R4";
      4'd9:       return "R5";
      default:    return "R10";
    endcase
  endfunction

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [15:0] im,
                     input logic ui, input logic [3:0] o, input string tag);
    logic [32:0] e;
    @(posedge clk);
    #1;
    a = x; b = y; imm = im; use_imm = ui; op = o;
    e = ref_out(x, ref_b(y, im, ui, o), o);
    @(negedge clk);
    n_checks++;
    if (res !== e[31:0] || ovf !== e[32]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b: actual res=%h ovf=%0b expected res=%h ovf=%0b",
               tag, o, x, y, im, ui, res, ovf, e[31:0], e[32]);
    end
  endtask

  initial begin
    int unsigned seed;
    a = '0; b = '0; imm = '0; use_imm = 1'b0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero result, no flag (R1)
    run(32'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R1 idle");
    // overflow boundaries R2 / R3
    run(32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 4'd0, "R2 max+1");
    run(32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 4'd1, "R3 addu max+1");
    run(32'h80000000, 32'h1, 16'h0, 1'b0, 4'd2, "R2 min-1");
    run(32'h80000000, 32'h1, 16'h0, 1'b0, 4'd3, "R3 subu min-1");
    run(32'h80000000, 32'h80000000, 16'h0, 1'b0, 4'd0, "R2 min+min");
    run(32'hFFFFFFFF, 32'h7FFFFFFF, 16'h0, 1'b0, 4'd2, "R2 no-ovf sub");
    run(32'h7FFFFFFF, 32'h0, 16'h0001, 1'b1, 4'd0, "R2 R6 addi ovf");
    run(32'h5, 32'h0, 16'hFFF6, 1'b1, 4'd0, "R1 R6 addi negative");
    // compares R4 / R5
    run(32'hFFFFFFFA, 32'h0000FFFA, 16'h0, 1'b0, 4'd8, "R4 slt");
    run(32'hFFFFFFFA, 32'h0000FFFA, 16'h0, 1'b0, 4'd9, "R5 sltu");
    run(32'hFFFFFFFA, 32'h0, 16'hFFFF, 1'b1, 4'd8, "R4 R6 slti");
    run(32'h00000001, 32'h0, 16'hFFFF, 1'b1, 4'd9, "R5 R6 sltiu");
    // logical immediates R7
    run(32'hDEADBEEF, 32'h0, 16'hFFFF, 1'b1, 4'd4, "R7 andi");
    run(32'hDEADBEEF, 32'h0, 16'h8001, 1'b1, 4'd5, "R7 ori");
    run(32'hF0F0F0F0, 32'h3C3C3C3C, 16'h0, 1'b0, 4'd4, "R8 and");
    // shifts R9
    run(32'h80000001, 32'hFFFFFFE0, 16'h0, 1'b0, 4'd6, "R9 sll by 0 masked");
    run(32'h80000001, 32'h0000001F, 16'h0, 1'b0, 4'd7, "R9 srl by 31");
    run(32'h80000001, 32'h0, 16'h001F, 1'b1, 4'd6, "R9 sll imm 31");
    // unused codes R10
    for (int c = 10; c < 16; c++) run(32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 4'(c), "R10 unused code");

    seed = 32'd12345;
    void'($urandom(seed));
    for (int k = 0; k < 3000; k++) begin
      logic [3:0]  o;
      logic [31:0] x, y;
      logic        ui;
      o  = 4'($urandom_range(0, 11));
      ui = 1'($urandom_range(0, 1));
      x  = $urandom();
      y  = $urandom();
      if ((k % 8) == 0) x = {x[31], 31'h7FFFFFFF ^ {31{x[31]}}};
      run(x, y, 16'($urandom()), ui, o, tag_of(o, ui));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule